// File: doc/BRIEF.md
# ADC Conversion Loop Sequencer

This block drives a 12-bit analog-to-digital converter through a sequence of up to sixteen conversion slots, called a loop. A loop is launched either by firmware, through a start bit in a 32-bit control word, or by a rising edge on one of sixteen trigger inputs. A trigger can be held back by a programmable delay counted in converter-clock periods, one converter clock being four system clocks.

For each slot the sequencer raises a one-cycle start pulse with the slot index. It waits for the converter's done strobe and stores the returned sample in a per-slot result register. The sample can be rounded to its ten most significant bits before it is stored. At the end of a loop the sequencer clears the firmware start bit and can set a sticky interrupt flag. It then either stops or begins the loop again at slot 0.

Software reaches the control word, the interrupt status and the sixteen results through a simple word-wide write/read port. Result slot k sits at address k (0 to 15), the control word at address 16 and the status word at address 17. Reads of the status word return the interrupt flag in bit 0.

Top module: `adc_loop_seq`

## Requirements
- R1: After reset the control word reads 0x00000700 (all fields 0 except bits 10-8, which are 1), the interrupt output is 0 and no start pulse is issued.
- R2: A loop converts slots 0, 1, ... up to the slot-count field (bits 7-4) in ascending order. Each slot gets exactly one single-cycle start pulse, and that pulse comes only after the previous slot's done strobe. A field value of 0 converts only slot 0 and a value of 15 converts all sixteen.
- R3: The sample returned for slot k is readable at address k after the loop.
- R4: With the rounding bit (bit 11) set, the stored value is min(raw+2, 4095) with its two low bits cleared; with it clear, the raw sample is stored unchanged.
- R5: Setting the firmware start bit (bit 2) launches a loop, and the bit reads back as 0 after the loop completes.
- R6: With the one-shot bit (bit 3) set, no start pulse follows the end of the loop.
- R7: With the one-shot bit clear, the loop restarts at slot 0 immediately after the last slot, without a new start request.
- R8: With the trigger enable (bit 20) set and the sequencer idle, a rising edge on the input selected by bits 19-16 launches a loop. The first start pulse is seen 4*D+2 clock cycles after the cycle in which the selected input is first sampled high, where D is bits 31-24.
- R9: With the trigger enable clear, a rising edge on the selected input launches nothing.
- R10: A rising edge on an input other than the selected one launches nothing.
- R11: The interrupt flag (status bit 0 and the irq output) is set at the end of a loop only if bit 1 is set. It stays set until software writes 1 to status bit 0.
- R12: While the enable bit (bit 0) is 0 no start pulse is issued, even with the firmware start bit set. Clearing it during a loop stops the loop within one cycle.
- R13: A trigger edge that arrives while a loop is running does not add a loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address: 0-15 results, 16 control, 17 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| trig_in | input | 16 | Trigger sources, one per select code |
| conv_start | output | 1 | One-cycle request to convert the slot on conv_slot |
| conv_slot | output | 4 | Slot index being converted |
| conv_done | input | 1 | Converter strobe: conv_data is valid |
| conv_data | input | 12 | Converter sample |
| irq | output | 1 | Sticky end-of-loop interrupt flag |

## Verification
The assertions take for granted that the converter answers each start pulse with one done strobe, and never raises done on its own. They also assume that software rewrites the slot-count field only while the sequencer is idle, or together with clearing the enable. The bench's converter model answers every start pulse with a single done strobe one cycle later. The bench changes the control word only between loops, except when it deliberately clears the enable to abort a continuous run.

// File: rtl/adc_seq_pkg.sv
// Package: shared constants and the sequencer state type.
// Assumes a 32-bit control word with the field positions listed below.
package adc_seq_pkg;
    localparam int NSLOT  = 16;
    localparam int SLOT_W = 4;
    localparam logic [31:0] CTRL_RESET = 32'h0000_0700;

    localparam int B_EN     = 0;
    localparam int B_IE     = 1;
    localparam int B_SW     = 2;
    localparam int B_ONCE   = 3;
    localparam int B_ROUND  = 11;
    localparam int B_EXT_EN = 20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_ISSUE,
        ST_WAIT
    } seq_state_t;
endpackage

// File: rtl/adc_trig_detect.sv
// Trigger selector and rising-edge detector.
// Selects one source by code and fires for one cycle on its rising edge
// while armed. Assumes the sources are already synchronous to clk.
module adc_trig_detect #(
    parameter int N_SRC = 16,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic [SEL_W-1:0] sel,
    input  logic             arm,
    output logic             fire
);
    logic cur;
    logic prev_q;

    assign cur = src[sel];

    // Remember the selected level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    assign fire = arm && cur && !prev_q;
endmodule

// File: rtl/adc_dly_timer.sv
// Trigger delay timer.
// Loads a count and decrements it once every DIV system clocks while run
// is high. Expired is high whenever the count is zero.
module adc_dly_timer #(
    parameter int CNT_W = 8,
    parameter int DIV   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] dly,
    output logic             expired
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;

    // Count converter-clock periods down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= '0;
        end else if (load) begin
            cnt_q <= dly;
            div_q <= '0;
        end else if (run && cnt_q != '0) begin
            if (div_q == DIV_LAST) begin
                div_q <= '0;
                cnt_q <= cnt_q - 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_result_store.sv
// Per-slot result registers with optional rounding to 10 MSBs.
// Rounding adds half an LSB of the kept width, saturates and clears the
// dropped bits. Assumes DATA_W is at least 11.
module adc_result_store #(
    parameter int DATA_W = 12,
    parameter int NSLOT  = 16,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] raw,
    input  logic              round_en,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data
);
    localparam int KEEP = 10;
    localparam int DROP = DATA_W - KEEP;
    localparam logic [DATA_W:0] HALF = (DATA_W + 1)'(1) << (DROP - 1);

    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] sat;
    logic [DATA_W-1:0] rounded;
    logic [DATA_W-1:0] stored;
    logic [DATA_W-1:0] res_q [NSLOT];

    // Round, saturate and truncate the incoming sample.
    always_comb begin
        sum     = {1'b0, raw} + HALF;
        sat     = sum[DATA_W] ? {DATA_W{1'b1}} : sum[DATA_W-1:0];
        rounded = {sat[DATA_W-1:DROP], {DROP{1'b0}}};
        stored  = round_en ? rounded : raw;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        // Capture the sample addressed to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 res_q[g] <= '0;
            else if (wr_en && wr_slot == SLOT_W'(g))    res_q[g] <= stored;
        end
    end

    assign rd_data = res_q[rd_slot];
endmodule

// File: rtl/adc_loop_seq.sv
// Conversion loop sequencer top.
// Holds the control word and interrupt flag, launches loops from firmware
// or a delayed trigger edge, steps the slots and hands samples to the
// result store. Assumes one done strobe per start pulse.
module adc_loop_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int N_TRIG = 16,
    parameter int CLK_DIV = 4,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [N_TRIG-1:0] trig_in,
    output logic              conv_start,
    output logic [SLOT_W-1:0] conv_slot,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NSLOT);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NSLOT + 1);
    localparam logic [ADDR_W-1:0] A_LAST_RES = ADDR_W'(NSLOT - 1);

    logic [31:0]       ctrl_q;
    logic              irq_q;
    seq_state_t        state_q;
    logic [SLOT_W-1:0] slot_q;

    logic              f_en, f_ie, f_sw, f_once, f_round, f_ext;
    logic [3:0]        f_max;
    logic [3:0]        f_sel;
    logic [7:0]        f_dly;

    logic              ctrl_wr;
    logic              stat_clr;
    logic              loop_end;
    logic              trig_fire;
    logic              trig_arm;
    logic              dly_expired;
    logic [DATA_W-1:0] rd_data;

    assign f_en    = ctrl_q[B_EN];
    assign f_ie    = ctrl_q[B_IE];
    assign f_sw    = ctrl_q[B_SW];
    assign f_once  = ctrl_q[B_ONCE];
    assign f_round = ctrl_q[B_ROUND];
    assign f_ext   = ctrl_q[B_EXT_EN];
    assign f_max   = ctrl_q[7:4];
    assign f_sel   = ctrl_q[19:16];
    assign f_dly   = ctrl_q[31:24];

    assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
    assign stat_clr = reg_wr && (reg_addr == A_STAT) && reg_wdata[0];
    assign loop_end = f_en && (state_q == ST_WAIT) && conv_done && (slot_q == f_max);
    assign trig_arm = f_en && f_ext && !f_sw && (state_q == ST_IDLE);

    adc_trig_detect #(
        .N_SRC(N_TRIG),
        .SEL_W(4)
    ) u_trig (
        .clk  (clk),
        .rst_n(rst_n),
        .src  (trig_in),
        .sel  (f_sel),
        .arm  (trig_arm),
        .fire (trig_fire)
    );

    adc_dly_timer #(
        .CNT_W(8),
        .DIV  (CLK_DIV)
    ) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (trig_fire),
        .run    (state_q == ST_DELAY),
        .dly    (f_dly),
        .expired(dly_expired)
    );

    adc_result_store #(
        .DATA_W(DATA_W),
        .NSLOT (NSLOT),
        .SLOT_W(SLOT_W)
    ) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (f_en && state_q == ST_WAIT && conv_done),
        .wr_slot (slot_q),
        .raw     (conv_data),
        .round_en(f_round),
        .rd_slot (reg_addr[SLOT_W-1:0]),
        .rd_data (rd_data)
    );

    // Control word: software write wins, else hardware clears the start bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= CTRL_RESET;
        else if (ctrl_wr)  ctrl_q <= reg_wdata;
        else if (loop_end) ctrl_q[B_SW] <= 1'b0;
    end

    // Sticky interrupt flag: setting at loop end wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                irq_q <= 1'b0;
        else if (loop_end && f_ie) irq_q <= 1'b1;
        else if (stat_clr)         irq_q <= 1'b0;
    end

    // Loop state machine: launch, delay, issue per slot, wait for done.
    always_ff @(posedge clk) begin
        if (!rst_n || !f_en) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    slot_q <= '0;
                    if (f_sw)           state_q <= ST_ISSUE;
                    else if (trig_fire) state_q <= ST_DELAY;
                end
                ST_DELAY: begin
                    if (dly_expired) state_q <= ST_ISSUE;
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (conv_done) begin
                        if (slot_q == f_max) begin
                            slot_q  <= '0;
                            state_q <= f_once ? ST_IDLE : ST_ISSUE;
                        end else begin
                            slot_q  <= slot_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Register read multiplexer.
    always_comb begin
        if (reg_addr == A_CTRL)           reg_rdata = ctrl_q;
        else if (reg_addr == A_STAT)      reg_rdata = {31'b0, irq_q};
        else if (reg_addr <= A_LAST_RES)  reg_rdata = 32'(rd_data);
        else                              reg_rdata = '0;
    end

    assign conv_start = f_en && (state_q == ST_ISSUE);
    assign conv_slot  = slot_q;
    assign irq        = irq_q;
endmodule

// File: rtl/adc_loop_seq_chk.sv
// Checker for the loop sequencer, bound to the top module.
// Assumes the slot-count field changes only while idle or with the
// enable being cleared.
module adc_loop_seq_chk #(
    parameter int SLOT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_start,
    input logic [SLOT_W-1:0] conv_slot,
    input logic              irq,
    input logic [31:0]       ctrl,
    input logic              ctrl_wr,
    input logic              stat_clr,
    input logic              loop_end
);
    // R2: start pulses are single cycles.
    p_start_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R2: the slot issued never exceeds the configured slot count.
    p_slot_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && $stable(ctrl[7:4])) |-> (conv_slot <= ctrl[7:4]));

    // R12: no start pulse unless the enable was already set.
    p_start_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(ctrl[0]));

    // R11: the flag holds until software clears it.
    p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_clr) |=> irq);

    // R11: the flag rises only at a loop end with the interrupt enabled.
    p_irq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(loop_end && ctrl[1]));

    // R5: the start bit is cleared at loop end unless software rewrites it.
    p_sw_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_end && !ctrl_wr) |=> !ctrl[2]);
endmodule

bind adc_loop_seq adc_loop_seq_chk #(.SLOT_W(4)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_start(conv_start),
    .conv_slot (conv_slot),
    .irq       (irq),
    .ctrl      (ctrl_q),
    .ctrl_wr   (ctrl_wr),
    .stat_clr  (stat_clr),
    .loop_end  (loop_end)
);

// File: tb/tb_adc_loop_seq.sv
// Scoreboard bench: tests push expected slots, the converter model checks
// slot order and pushes expected stored values, readback compares them.
module tb_adc_loop_seq;
    localparam int A_CTRL = 16;
    localparam int A_STAT = 17;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [15:0] trig_in;
    logic        conv_start;
    logic [3:0]  conv_slot;
    logic        conv_done;
    logic [11:0] conv_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    int data_base = 0;
    int data_step = 1;
    bit round_mode = 1'b0;
    int exp_slot_q[$];
    int res_slot_q[$];
    int res_val_q[$];

    always #4 clk = ~clk;

    adc_loop_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .trig_in   (trig_in),
        .conv_start(conv_start),
        .conv_slot (conv_slot),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .irq       (irq)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic int expect_store(int raw, bit rnd);
        int s;
        if (!rnd) return raw;
        s = raw + 2;
        if (s > 4095) s = 4095;
        return s & 32'hFFC;
    endfunction

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 5'(a);
        #1 d = reg_rdata;
    endtask

    task automatic push_slots(int last);
        for (int i = 0; i <= last; i++) exp_slot_q.push_back(i);
    endtask

    task automatic check_results(string tag);
        logic [31:0] d;
        while (res_slot_q.size() > 0) begin
            int s;
            int v;
            s = res_slot_q.pop_front();
            v = res_val_q.pop_front();
            rd(s, d);
            chk(tag, int'(d), v);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Converter model and monitor: checks slot order, answers with done.
    initial begin
        conv_done = 1'b0;
        conv_data = '0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (conv_start) begin
                int s;
                int raw;
                starts++;
                s = int'(conv_slot);
                if (exp_slot_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 unexpected start: actual slot %0d expected none", s);
                end else begin
                    chk("R2 slot order", s, exp_slot_q.pop_front());
                end
                raw = (data_base + s * data_step) % 4096;
                res_slot_q.push_back(s);
                res_val_q.push_back(expect_store(raw, round_mode));
                @(negedge clk);
                conv_data = 12'(raw);
                conv_done = 1'b1;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Test sequence.
    initial begin
        logic [31:0] d;
        int n;
        int snap;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; trig_in = '0;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, d);  chk("R1 ctrl reset", int'(d), 32'h0000_0700);
        rd(A_STAT, d);  chk("R1 status reset", int'(d), 0);
        chk("R1 irq reset", int'(irq), 0);
        chk("R1 no start", int'(conv_start), 0);

        // R2 R3 R5 R6 R11: firmware start, 4 slots, one-shot, irq enabled
        data_base = 100; data_step = 300; round_mode = 1'b0;
        starts = 0; push_slots(3);
        wr(A_CTRL, 32'h0000_073F);
        idle(30);
        chk("R2 start count 4 slots", starts, 4);
        check_results("R3 result readback");
        rd(A_CTRL, d);  chk("R5 start bit cleared", int'(d), 32'h0000_073B);
        chk("R11 irq set at loop end", int'(irq), 1);
        idle(40);
        chk("R6 no restart in one-shot", starts, 4);
        rd(A_STAT, d);  chk("R11 irq sticky", int'(d), 1);
        wr(A_STAT, 32'h1);
        chk("R11 irq cleared by write", int'(irq), 0);

        // R4 R2: all 16 slots with rounding, irq disabled
        data_base = 4093; data_step = 1; round_mode = 1'b1;
        starts = 0; push_slots(15);
        wr(A_CTRL, 32'h0000_0FFD);
        idle(60);
        chk("R2 start count 16 slots", starts, 16);
        check_results("R4 rounded result");
        chk("R11 no irq when disabled", int'(irq), 0);

        // R2 boundary: single slot
        data_base = 7; data_step = 5; round_mode = 1'b0;
        starts = 0; push_slots(0);
        wr(A_CTRL, 32'h0000_070D);
        idle(20);
        chk("R2 single slot loop", starts, 1);
        check_results("R3 single slot result");

        // R8: trigger on source 5, delay 0
        starts = 0; push_slots(1);
        wr(A_CTRL, 32'h0015_0719);
        @(negedge clk); trig_in[5] = 1'b1; n = 0;
        while (!conv_start && n < 100) begin @(negedge clk); n++; end
        chk("R8 latency delay 0", n, 2);
        idle(20); trig_in[5] = 1'b0;
        chk("R8 loop from trigger", starts, 2);
        res_slot_q.delete(); res_val_q.delete();

        // R8 R13: delay 3, 8 slots, second edge during the loop
        starts = 0; push_slots(7);
        wr(A_CTRL, 32'h0315_0779);
        @(negedge clk); trig_in[5] = 1'b1; n = 0;
        while (!conv_start && n < 100) begin @(negedge clk); n++; end
        chk("R8 latency delay 3", n, 14);
        @(negedge clk); trig_in[5] = 1'b0;
        @(negedge clk); trig_in[5] = 1'b1;
        idle(40);
        chk("R13 edge during loop ignored", starts, 8);
        trig_in[5] = 1'b0;
        res_slot_q.delete(); res_val_q.delete();

        // R10: edge on a non-selected source
        starts = 0;
        wr(A_CTRL, 32'h0015_0709);
        @(negedge clk); trig_in[2] = 1'b1;
        idle(30);
        chk("R10 other source ignored", starts, 0);
        trig_in[2] = 1'b0;

        // R9: trigger enable clear
        wr(A_CTRL, 32'h0005_0709);
        @(negedge clk); trig_in[5] = 1'b1;
        idle(30);
        chk("R9 trigger disabled ignored", starts, 0);
        trig_in[5] = 1'b0;

        // R12: start bit with enable clear
        wr(A_CTRL, 32'h0000_070C);
        idle(30);
        chk("R12 no start while disabled", starts, 0);

        // R7 R12: continuous 3-slot loop, then abort
        data_base = 50; data_step = 10; round_mode = 1'b0;
        for (int k = 0; k < 4; k++) push_slots(2);
        wr(A_CTRL, 32'h0000_0725);
        idle(16);
        chk("R7 continuous restarts", int'(starts >= 6), 1);
        wr(A_CTRL, 32'h0000_0700);
        idle(2);
        snap = starts;
        idle(30);
        chk("R12 abort stops starts", starts, snap);
        exp_slot_q.delete(); res_slot_q.delete(); res_val_q.delete();

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule